// File: doc/BRIEF.md
# Burst-Mode Digital Power-Control Loop

This controller keeps a laser's average optical power steady by steering a digital bias code. The code feeds a DAC that lies outside the block. An analog comparator, also outside the block, reports each cycle whether the monitor photocurrent is still below its reference. The controller turns that single bit into bias corrections.

After power-on reset, or when the disable input falls, the controller runs a start-up sequence in three parts:
- a safety wait with no bias applied;
- a coarse search that settles one code bit at a time, from the most significant down;
- one-LSB tracking at a bounded rate.

The active-low fail flag stays low for a fixed initialization window, and the window is longer when the long-init select is high. After that window, the flag drops whenever the loop asks to move past either end of the code range.

Between bursts (burst-enable low) the bias and modulation enables turn off and the code is frozen. The next burst starts from that stored value. Tying burst-enable high gives continuous operation. All times are cycle counts set by parameters.

Top module: `apc_loop_ctrl`

## Requirements
- R1: While `rst` or `dis_i` is high, every clock edge leaves `bias_code_o` = 0, `bias_en_o` = 0, `mod_en_o` = 0 and `fail_n_o` = 0.
- R2: The first edge that samples `rst` low and `dis_i` low starts initialization. With `burst_i` high, `bias_en_o` and `mod_en_o` are still 0 after SLOW_CYC edges, counting that edge, and become 1 after SLOW_CYC+1 edges.
- R3: The coarse search spends SETTLE_CYC burst-high edges on each code bit, from MSB to LSB. A trial bit is kept only if the comparator reports below. With a monitor that reads below exactly when the code is less than T (1 <= T <= MAX_CODE+1), `bias_code_o` equals T-1 after SLOW_CYC+1+CODE_W*SETTLE_CYC edges from the start.
- R4: A trial bit whose setting would push the code above MAX_CODE is left clear during the coarse search.
- R5: After the coarse search, the code changes by exactly one LSB once every UPD_CYC burst-high edges. It steps up when the comparator reports below and down otherwise.
- R6: With `burst_i` held high, `fail_n_o` stays 0 for the first INIT_SHORT_CYC edges from the start and rises on edge INIT_SHORT_CYC+1 if `long_i` was low on the start edge. If `long_i` was high on the start edge, the figures are INIT_LONG_CYC and INIT_LONG_CYC+1.
- R7: While `burst_i` is low, `bias_en_o` and `mod_en_o` are 0 and the code does not change. When `burst_i` returns high, tracking resumes from the stored code.
- R8: After initialization, an upward request at code MAX_CODE leaves the code at MAX_CODE and drives `fail_n_o` to 0.
- R9: After initialization, a downward request at code 0 leaves the code at 0 and drives `fail_n_o` to 0.
- R10: A saturation failure clears, and `fail_n_o` returns to 1, on the first update that moves the code.
- R11: `bias_code_o` never exceeds MAX_CODE.
- R12: Raising `dis_i` during operation discards the stored code. Lowering it again runs the whole initialization sequence from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dis_i | input | 1 | Disable, active high; resets all loop state |
| burst_i | input | 1 | Burst enable; high lets the loop adjust and drive bias |
| long_i | input | 1 | Long initialization select, sampled at start |
| below_i | input | 1 | Comparator result: monitor below reference |
| bias_code_o | output | CODE_W | Bias DAC code |
| bias_en_o | output | 1 | Bias current enable |
| mod_en_o | output | 1 | Modulation current enable |
| fail_n_o | output | 1 | Loop failure flag, active low |

## Verification
Saturation at the upper end is the hardest state to reach from the ports. It needs a reference above what MAX_CODE can supply, so that the coarse search has to skip trial bits that overshoot. The bench's plant model sets the target beyond the ceiling. Once initialization ends, it checks that the code sits at MAX_CODE with the flag low. It then lowers the target to show that the flag recovers after exactly one step. Exact cycle positions are also hard to hit. The bench counts edges from the start edge to confirm the slow-start length, the coarse-search result and both initialization windows.

// File: rtl/apc_loop_pkg.sv
package apc_loop_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_SLOW   = 2'd1,
        PH_COARSE = 2'd2,
        PH_TRACK  = 2'd3
    } apc_phase_e;

    typedef struct packed {
        apc_phase_e phase;
        logic       coarse_start;
        logic       active;
    } apc_ctl_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/apc_phase_ctl.sv
module apc_phase_ctl
    import apc_loop_pkg::*;
#(
    parameter int unsigned SLOW_CYC       = 8,
    parameter int unsigned INIT_SHORT_CYC = 60,
    parameter int unsigned INIT_LONG_CYC  = 100
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     dis_i,
    input  logic     burst_i,
    input  logic     long_i,
    input  logic     coarse_done_i,
    output apc_ctl_t ctl_o,
    output logic     init_done_o
);
    localparam int unsigned SHORT_WIN = INIT_SHORT_CYC - SLOW_CYC;
    localparam int unsigned LONG_WIN  = INIT_LONG_CYC - SLOW_CYC;
    localparam int unsigned WIN_MAX   = (LONG_WIN > SHORT_WIN) ? LONG_WIN : SHORT_WIN;
    localparam int unsigned SLOW_W    = cnt_w(SLOW_CYC);
    localparam int unsigned TMR_W     = cnt_w(WIN_MAX + 1);

    apc_phase_e          phase_q;
    logic [SLOW_W-1:0]   slow_q;
    logic [TMR_W-1:0]    tmr_q;
    logic                long_q;
    logic [TMR_W-1:0]    win;
    logic                active;
    logic                slow_end;

    assign win      = long_q ? TMR_W'(LONG_WIN) : TMR_W'(SHORT_WIN);
    assign active   = (phase_q == PH_COARSE) || (phase_q == PH_TRACK);
    assign slow_end = (phase_q == PH_SLOW) && (slow_q == SLOW_W'(SLOW_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || dis_i) begin
            phase_q <= PH_OFF;
            slow_q  <= '0;
            tmr_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_OFF: begin
                    phase_q <= PH_SLOW;
                    slow_q  <= '0;
                    tmr_q   <= '0;
                    long_q  <= long_i;
                end
                PH_SLOW: begin
                    if (slow_end) phase_q <= PH_COARSE;
                    else          slow_q  <= slow_q + 1'b1;
                end
                PH_COARSE: begin
                    if (coarse_done_i) phase_q <= PH_TRACK;
                end
                default: ;
            endcase
            if (active && burst_i && (tmr_q < win))
                tmr_q <= tmr_q + 1'b1;
        end
    end

    assign ctl_o.phase        = phase_q;
    assign ctl_o.coarse_start = slow_end;
    assign ctl_o.active       = active;
    assign init_done_o        = active && (tmr_q >= win);

    // R2
    slow_full_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_COARSE && $past(phase_q) == PH_SLOW) |-> ($past(slow_q) == SLOW_W'(SLOW_CYC - 1)));

    // R6
    init_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(!active)) |-> !init_done_o);

endmodule

// File: rtl/apc_code_engine.sv
module apc_code_engine
    import apc_loop_pkg::*;
#(
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned MAX_CODE   = 200,
    parameter int unsigned SETTLE_CYC = 3,
    parameter int unsigned UPD_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dis_i,
    input  logic              burst_i,
    input  logic              below_i,
    input  apc_ctl_t          ctl_i,
    output logic              coarse_done_o,
    output logic [CODE_W-1:0] code_o,
    output logic              sat_o
);
    localparam int unsigned IDX_W = cnt_w(CODE_W);
    localparam int unsigned SET_W = cnt_w(SETTLE_CYC);
    localparam int unsigned UPD_W = cnt_w(UPD_CYC);
    localparam logic [CODE_W-1:0] MAXC = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] code_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SET_W-1:0]  settle_q;
    logic [UPD_W-1:0]  upd_q;
    logic              sat_q;

    logic              step_now;
    logic              track_tick;
    logic [CODE_W-1:0] decided;

    function automatic logic [CODE_W-1:0] bit_at(input logic [IDX_W-1:0] pos);
        return CODE_W'(1) << pos;
    endfunction

    function automatic logic [CODE_W-1:0] fit_trial(input logic [CODE_W-1:0] base,
                                                     input logic [IDX_W-1:0]  pos);
        logic [CODE_W-1:0] cand;
        cand = base | bit_at(pos);
        return (cand > MAXC) ? base : cand;
    endfunction

    assign step_now   = (ctl_i.phase == PH_COARSE) && burst_i && (settle_q == SET_W'(SETTLE_CYC - 1));
    assign track_tick = (ctl_i.phase == PH_TRACK) && burst_i && (upd_q == UPD_W'(UPD_CYC - 1));
    assign decided    = ((code_q & bit_at(idx_q)) != '0 && !below_i) ? (code_q & ~bit_at(idx_q)) : code_q;
    assign coarse_done_o = step_now && (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst || dis_i) begin
            code_q   <= '0;
            idx_q    <= '0;
            settle_q <= '0;
            upd_q    <= '0;
            sat_q    <= 1'b0;
        end else if (ctl_i.coarse_start) begin
            code_q   <= fit_trial('0, IDX_W'(CODE_W - 1));
            idx_q    <= IDX_W'(CODE_W - 1);
            settle_q <= '0;
            upd_q    <= '0;
            sat_q    <= 1'b0;
        end else if (ctl_i.phase == PH_COARSE && burst_i) begin
            if (step_now) begin
                settle_q <= '0;
                if (idx_q == '0) begin
                    code_q <= decided;
                    upd_q  <= '0;
                end else begin
                    code_q <= fit_trial(decided, idx_q - 1'b1);
                    idx_q  <= idx_q - 1'b1;
                end
            end else begin
                settle_q <= settle_q + 1'b1;
            end
        end else if (ctl_i.phase == PH_TRACK && burst_i) begin
            if (track_tick) begin
                upd_q <= '0;
                if (below_i) begin
                    if (code_q >= MAXC) sat_q <= 1'b1;
                    else begin
                        code_q <= code_q + 1'b1;
                        sat_q  <= 1'b0;
                    end
                end else begin
                    if (code_q == '0) sat_q <= 1'b1;
                    else begin
                        code_q <= code_q - 1'b1;
                        sat_q  <= 1'b0;
                    end
                end
            end else begin
                upd_q <= upd_q + 1'b1;
            end
        end
    end

    assign code_o = code_q;
    assign sat_o  = sat_q;

    // R11
    code_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_q <= MAXC);

    // R12
    code_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> (code_q == '0));

    // R5
    fine_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.phase == PH_TRACK && !dis_i) |=>
        (code_q == $past(code_q) || code_q == $past(code_q) + CODE_W'(1) || code_q == $past(code_q) - CODE_W'(1)));

    // R7
    burst_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.active && !burst_i && !dis_i) |=> $stable(code_q));

endmodule

// File: rtl/apc_loop_ctrl.sv
module apc_loop_ctrl
    import apc_loop_pkg::*;
#(
    parameter int unsigned CODE_W         = 8,
    parameter int unsigned MAX_CODE       = 200,
    parameter int unsigned SLOW_CYC       = 8,
    parameter int unsigned SETTLE_CYC     = 3,
    parameter int unsigned UPD_CYC        = 4,
    parameter int unsigned INIT_SHORT_CYC = 60,
    parameter int unsigned INIT_LONG_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dis_i,
    input  logic              burst_i,
    input  logic              long_i,
    input  logic              below_i,
    output logic [CODE_W-1:0] bias_code_o,
    output logic              bias_en_o,
    output logic              mod_en_o,
    output logic              fail_n_o
);
    apc_ctl_t ctl;
    logic     coarse_done;
    logic     init_done;
    logic     sat;

    apc_phase_ctl #(
        .SLOW_CYC       (SLOW_CYC),
        .INIT_SHORT_CYC (INIT_SHORT_CYC),
        .INIT_LONG_CYC  (INIT_LONG_CYC)
    ) u_phase (
        .clk           (clk),
        .rst           (rst),
        .dis_i         (dis_i),
        .burst_i       (burst_i),
        .long_i        (long_i),
        .coarse_done_i (coarse_done),
        .ctl_o         (ctl),
        .init_done_o   (init_done)
    );

    apc_code_engine #(
        .CODE_W     (CODE_W),
        .MAX_CODE   (MAX_CODE),
        .SETTLE_CYC (SETTLE_CYC),
        .UPD_CYC    (UPD_CYC)
    ) u_engine (
        .clk           (clk),
        .rst           (rst),
        .dis_i         (dis_i),
        .burst_i       (burst_i),
        .below_i       (below_i),
        .ctl_i         (ctl),
        .coarse_done_o (coarse_done),
        .code_o        (bias_code_o),
        .sat_o         (sat)
    );

    assign bias_en_o = ctl.active && burst_i;
    assign mod_en_o  = ctl.active && burst_i;
    assign fail_n_o  = init_done && !sat;

    // R6
    init_fail_low_chk: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !fail_n_o);

    // R1
    dis_outputs_off_chk: assert property (@(posedge clk) disable iff (rst)
        dis_i |=> (!bias_en_o && !mod_en_o && !fail_n_o));

    // R7
    enable_needs_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (bias_en_o || mod_en_o) |-> burst_i);

endmodule

// File: tb/apc_loop_ctrl_bench.sv
module apc_loop_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 8;
    localparam int MAX_CODE   = 200;
    localparam int SLOW       = 8;
    localparam int SETTLE     = 3;
    localparam int UPD        = 4;
    localparam int INIT_S     = 60;
    localparam int INIT_L     = 100;
    localparam int COARSE_END = SLOW + 1 + CODE_W * SETTLE;

    logic clk = 1'b0;
    logic rst, dis, burst, lng;
    logic [CODE_W-1:0] code;
    logic bias_en, mod_en, fail_n;
    int   target;
    logic below;
    int   checks = 0;
    int   failures = 0;

    assign below = (int'(code) < target);

    always #(CLK_PERIOD / 2) clk = ~clk;

    apc_loop_ctrl u_apc_loop_ctrl (
        .clk         (clk),
        .rst         (rst),
        .dis_i       (dis),
        .burst_i     (burst),
        .long_i      (lng),
        .below_i     (below),
        .bias_code_o (code),
        .bias_en_o   (bias_en),
        .mod_en_o    (mod_en),
        .fail_n_o    (fail_n)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic long_sel);
        dis = 1'b1;
        lng = long_sel;
        tick();
        dis = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; dis = 1'b0; burst = 1'b1; lng = 1'b0; target = 77;
        repeat (3) tick();
        chk(code == 0 && !bias_en && !mod_en && !fail_n, "R1 reset outputs", int'(code), 0);
        rst = 1'b0;
        for (int n = 1; n <= SLOW + 1; n++) begin
            tick();
            if (n == SLOW) chk(!bias_en && !mod_en, "R2 por slow-start still off", int'(bias_en), 0);
            if (n == SLOW + 1) chk(bias_en && mod_en, "R2 por enables on", int'(bias_en), 1);
        end
    endtask

    task automatic t_disable_hold();
        dis = 1'b1; burst = 1'b1;
        for (int n = 0; n < 10; n++) begin
            tick();
            if (bias_en || mod_en || code != 0 || fail_n) begin
                chk(1'b0, "R1 disable hold", int'(code), 0);
                break;
            end
        end
        chk(!bias_en && code == 0 && !fail_n, "R1 disable hold end", int'(bias_en), 0);
    endtask

    task automatic t_startup();
        logic early_fail;
        early_fail = 1'b0;
        target = 77; burst = 1'b1;
        launch(1'b0);
        for (int n = 1; n <= INIT_S + 1; n++) begin
            tick();
            if (n == SLOW) chk(!bias_en, "R2 slow-start off", int'(bias_en), 0);
            if (n == SLOW + 1) chk(bias_en && mod_en, "R2 enables on", int'(bias_en), 1);
            if (n == COARSE_END) chk(code == 76, "R3 coarse result", int'(code), 76);
            if (n == COARSE_END + UPD - 1) chk(code == 76, "R5 no early step", int'(code), 76);
            if (n == COARSE_END + UPD) chk(code == 77, "R5 one LSB up", int'(code), 77);
            if (n == COARSE_END + 2 * UPD) chk(code == 76, "R5 one LSB down", int'(code), 76);
            if (n <= INIT_S && fail_n) early_fail = 1'b1;
            if (n == INIT_S + 1) chk(fail_n, "R6 short init end", int'(fail_n), 1);
        end
        chk(!early_fail, "R6 fail low during short init", int'(early_fail), 0);
    endtask

    task automatic t_long_init();
        target = 50; burst = 1'b1;
        launch(1'b1);
        for (int n = 1; n <= INIT_L + 1; n++) begin
            tick();
            if (n == INIT_S + 1) chk(!fail_n, "R6 long init still low", int'(fail_n), 0);
            if (n == INIT_L) chk(!fail_n, "R6 long init last low", int'(fail_n), 0);
            if (n == INIT_L + 1) chk(fail_n, "R6 long init end", int'(fail_n), 1);
        end
    endtask

    task automatic t_freeze();
        logic [CODE_W-1:0] held;
        logic moved;
        moved = 1'b0;
        burst = 1'b0;
        tick();
        held = code;
        chk(!bias_en && !mod_en, "R7 enables off between bursts", int'(bias_en), 0);
        target = 10;
        for (int n = 0; n < 20; n++) begin
            tick();
            if (code != held) moved = 1'b1;
        end
        chk(!moved && code == held, "R7 code frozen", int'(code), int'(held));
        burst = 1'b1;
        tick();
        chk(bias_en, "R7 burst resumes", int'(bias_en), 1);
        repeat (UPD - 1) tick();
        chk(int'(code) == int'(held) - 1, "R7 resume from stored code", int'(code), int'(held) - 1);
    endtask

    task automatic t_sat_high();
        target = 250; burst = 1'b1;
        launch(1'b0);
        for (int n = 1; n <= INIT_S + 1; n++) begin
            tick();
            if (n == COARSE_END) chk(code == MAX_CODE, "R4 coarse skips over-ceiling bits", int'(code), MAX_CODE);
        end
        chk(!fail_n && code == MAX_CODE, "R8 upper saturation flag", int'(fail_n), 0);
        target = 100;
        repeat (UPD) tick();
        chk(code == MAX_CODE - 1, "R10 stepped down", int'(code), MAX_CODE - 1);
        chk(fail_n, "R10 fail cleared", int'(fail_n), 1);
    endtask

    task automatic t_sat_low();
        target = 0; burst = 1'b1;
        launch(1'b0);
        repeat (INIT_S + 1) tick();
        chk(!fail_n && code == 0, "R9 lower saturation flag", int'(fail_n), 0);
        target = 30;
        repeat (UPD) tick();
        chk(fail_n && code == 1, "R10 clears after up step", int'(code), 1);
    endtask

    task automatic t_dis_midrun();
        target = 90; burst = 1'b1;
        repeat (40) tick();
        dis = 1'b1;
        tick();
        chk(code == 0 && !bias_en && !fail_n, "R12 disable clears code", int'(code), 0);
        dis = 1'b0;
        for (int n = 1; n <= COARSE_END; n++) begin
            tick();
            if (n == SLOW) chk(!bias_en, "R12 re-init slow-start", int'(bias_en), 0);
            if (n == COARSE_END) chk(code == 89, "R12 re-init coarse", int'(code), 89);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_disable_hold();
        t_startup();
        t_freeze();
        t_long_init();
        t_sat_high();
        t_sat_low();
        t_dis_midrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule